// File: doc/BRIEF.md
# Highway and Farm Road Crossing Light Sequencer

This block sequences the lamps at a crossing where a busy highway meets a lightly used farm road. The highway normally holds green. A sensor on the farm road reports a waiting vehicle on `car_waiting`. The controller moves through four phases: highway green, highway yellow, farm green and farm yellow. Two internal down-counters time the phases. The short counter times each yellow phase. The long counter sets the minimum time for each green phase.

The controller is a Mealy machine. It raises `start_timing` for one cycle, only in a cycle where the phase is about to change. That pulse reloads both counters at the same clock edge. Each counter counts down to zero, stops there, and holds its expiry flag high until the next reload. The six lamp outputs are decoded from the registered phase alone. The interval lengths are parameters: `SHORT_LEN` defaults to 4 cycles and `LONG_LEN` to 16 cycles.

Top module: `tlc_crossing`

## Requirements
- R1: While `rst_n` is low, `phase` is 2'b00 (highway green), the highway green and farm red lamps are lit, and `short_done` and `long_done` are 0. Reset loads both counters with their full lengths.
- R2: In highway green (2'b00), the next phase is highway yellow (2'b01) only when `long_done` and `car_waiting` are both 1, and `start_timing` is 1 in that cycle. Otherwise the phase holds.
- R3: In highway yellow (2'b01), the next phase is farm green (2'b11) when `short_done` is 1, with `start_timing` high. Otherwise the phase holds.
- R4: In farm green (2'b11), the next phase is farm yellow (2'b10) when `long_done` is 1 and `car_waiting` is 0, with `start_timing` high. Otherwise the phase holds.
- R5: In farm yellow (2'b10), the next phase is highway green (2'b00) when `short_done` is 1, with `start_timing` high. Otherwise the phase holds.
- R6: `start_timing` is 0 in every cycle where the phase does not change.
- R7: Each clock edge with `start_timing` high reloads both counters. `short_done` then rises exactly `SHORT_LEN` edges later and `long_done` exactly `LONG_LEN` edges later, unless another reload comes first.
- R8: Once a counter reaches zero it stays at zero, and its flag stays 1 until the next reload.
- R9: The lamps follow the phase only, with exactly one lamp lit per road:
  - 2'b00: highway green, farm red.
  - 2'b01: highway yellow, farm red.
  - 2'b11: highway red, farm green.
  - 2'b10: highway red, farm yellow.
  - Each phase change flips exactly one bit of `phase`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| car_waiting | input | 1 | Vehicle present on the farm road |
| start_timing | output | 1 | One-cycle pulse on a phase change; reloads both counters |
| short_done | output | 1 | Short interval expired |
| long_done | output | 1 | Long interval expired |
| phase | output | 2 | Current phase code |
| hwy_green | output | 1 | Highway green lamp |
| hwy_yellow | output | 1 | Highway yellow lamp |
| hwy_red | output | 1 | Highway red lamp |
| farm_green | output | 1 | Farm road green lamp |
| farm_yellow | output | 1 | Farm road yellow lamp |
| farm_red | output | 1 | Farm road red lamp |

## Verification
The bench keeps `car_waiting` low long after `long_done` rises. A controller that leaves highway green on the long interval alone would then cycle the lights for an empty farm road. The bench also keeps a vehicle present through farm green, where a controller that ignores `car_waiting` there would cut the farm green short. Random arrivals land just before and just after expiry. These catch a reload that is off by one cycle, a reload that hits only one counter, and a flag that drops or wraps once the count reaches zero. Lamps are compared in every cycle, so a wrong phase code or an input-driven lamp shows up at once.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    typedef enum logic [1:0] {
        PH_HWY_GO    = 2'b00,
        PH_HWY_WARN  = 2'b01,
        PH_FARM_WARN = 2'b10,
        PH_FARM_GO   = 2'b11
    } phase_e;

    typedef struct packed {
        logic green;
        logic yellow;
        logic red;
    } lamp_t;

    typedef struct packed {
        phase_e phase;
    } seq_regs_t;

endpackage

// File: rtl/tlc_interval_timer.sv
module tlc_interval_timer #(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    output logic expired
);
    localparam int unsigned CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(LEN);

    logic [CW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (reload) begin
            count_d = LOAD;
        end else if (count_q != '0) begin
            count_d = count_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= LOAD;
        else        count_q <= count_d;
    end

    assign expired = (count_q == '0);

    // A reload clears the flag on the next edge (R7).
    assert_reload_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !expired);

    // An expired counter stays expired until reloaded (R8).
    assert_flag_latches_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !reload) |=> expired);

endmodule

// File: rtl/tlc_sequencer.sv
module tlc_sequencer
    import tlc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   car,
    input  logic   short_done,
    input  logic   long_done,
    output phase_e phase,
    output logic   start
);
    seq_regs_t cur_q, nxt_d;
    logic      start_d;

    always_comb begin
        nxt_d   = cur_q;
        start_d = 1'b0;
        unique case (cur_q.phase)
            PH_HWY_GO: begin
                if (long_done && car) begin
                    nxt_d.phase = PH_HWY_WARN;
                    start_d     = 1'b1;
                end
            end
            PH_HWY_WARN: begin
                if (short_done) begin
                    nxt_d.phase = PH_FARM_GO;
                    start_d     = 1'b1;
                end
            end
            PH_FARM_GO: begin
                if (long_done && !car) begin
                    nxt_d.phase = PH_FARM_WARN;
                    start_d     = 1'b1;
                end
            end
            PH_FARM_WARN: begin
                if (short_done) begin
                    nxt_d.phase = PH_HWY_GO;
                    start_d     = 1'b1;
                end
            end
            default: begin
                nxt_d.phase = PH_HWY_GO;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q.phase <= PH_HWY_GO;
        else        cur_q       <= nxt_d;
    end

    assign phase = cur_q.phase;
    assign start = start_d;

    assert_hwy_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.phase == PH_HWY_GO && !(long_done && car)) |=> cur_q.phase == PH_HWY_GO);

    assert_hwy_warn_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.phase == PH_HWY_WARN && !short_done) |=> cur_q.phase == PH_HWY_WARN);

    assert_farm_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.phase == PH_FARM_GO && (!long_done || car)) |=> cur_q.phase == PH_FARM_GO);

    assert_farm_warn_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.phase == PH_FARM_WARN && short_done) |=> cur_q.phase == PH_HWY_GO);

    assert_quiet_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(cur_q.phase));

    assert_single_bit_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $countones(cur_q.phase ^ $past(cur_q.phase)) <= 1);

endmodule

// File: rtl/tlc_lamp_decode.sv
module tlc_lamp_decode
    import tlc_pkg::*;
(
    input  phase_e phase,
    output lamp_t  hwy,
    output lamp_t  farm
);
    always_comb begin
        hwy  = '{green: 1'b0, yellow: 1'b0, red: 1'b1};
        farm = '{green: 1'b0, yellow: 1'b0, red: 1'b1};
        case (phase)
            PH_HWY_GO:    hwy.green   = 1'b1;
            PH_HWY_WARN:  hwy.yellow  = 1'b1;
            PH_FARM_GO:   farm.green  = 1'b1;
            PH_FARM_WARN: farm.yellow = 1'b1;
            default:      hwy.green   = 1'b1;
        endcase
        if (phase == PH_HWY_GO)   hwy.red  = 1'b0;
        if (phase == PH_HWY_WARN) hwy.red  = 1'b0;
        if (phase == PH_FARM_GO)  farm.red = 1'b0;
        if (phase == PH_FARM_WARN) farm.red = 1'b0;
    end
endmodule

// File: rtl/tlc_crossing.sv
module tlc_crossing #(
    parameter int unsigned SHORT_LEN = 4,
    parameter int unsigned LONG_LEN  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       car_waiting,
    output logic       start_timing,
    output logic       short_done,
    output logic       long_done,
    output logic [1:0] phase,
    output logic       hwy_green,
    output logic       hwy_yellow,
    output logic       hwy_red,
    output logic       farm_green,
    output logic       farm_yellow,
    output logic       farm_red
);
    import tlc_pkg::*;

    phase_e ph;
    logic   st;
    lamp_t  hwy_l, farm_l;

    tlc_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .car        (car_waiting),
        .short_done (short_done),
        .long_done  (long_done),
        .phase      (ph),
        .start      (st)
    );

    tlc_interval_timer #(.LEN(SHORT_LEN)) u_short (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (st),
        .expired (short_done)
    );

    tlc_interval_timer #(.LEN(LONG_LEN)) u_long (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (st),
        .expired (long_done)
    );

    tlc_lamp_decode u_lamps (
        .phase (ph),
        .hwy   (hwy_l),
        .farm  (farm_l)
    );

    assign start_timing = st;
    assign phase        = ph;
    assign hwy_green    = hwy_l.green;
    assign hwy_yellow   = hwy_l.yellow;
    assign hwy_red      = hwy_l.red;
    assign farm_green   = farm_l.green;
    assign farm_yellow  = farm_l.yellow;
    assign farm_red     = farm_l.red;

    // One pulse restarts both counters together (R7).
    assert_both_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_timing |=> (!short_done && !long_done));

    // Exactly one lamp per road (R9).
    assert_lamp_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({hwy_green, hwy_yellow, hwy_red}) && $onehot({farm_green, farm_yellow, farm_red}));

endmodule

// File: tb/tb_tlc_crossing.sv
`timescale 1ns/1ps
module tb_tlc_crossing;
    localparam int SHORT_LEN = 4;
    localparam int LONG_LEN  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic car_waiting = 1'b0;
    logic start_timing, short_done, long_done;
    logic [1:0] phase;
    logic hwy_green, hwy_yellow, hwy_red, farm_green, farm_yellow, farm_red;

    int total = 0;
    int bad = 0;

    int m_state = 0;
    int m_s = SHORT_LEN;
    int m_l = LONG_LEN;

    always #10 clk = ~clk;

    tlc_crossing #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) dut (
        .clk(clk), .rst_n(rst_n), .car_waiting(car_waiting),
        .start_timing(start_timing), .short_done(short_done), .long_done(long_done),
        .phase(phase), .hwy_green(hwy_green), .hwy_yellow(hwy_yellow), .hwy_red(hwy_red),
        .farm_green(farm_green), .farm_yellow(farm_yellow), .farm_red(farm_red)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int lamps_for(input int s);
        // {hg,hy,hr,fg,fy,fr}
        case (s)
            0: return 6'b100_001;
            1: return 6'b010_001;
            3: return 6'b001_100;
            default: return 6'b001_010;
        endcase
    endfunction

    task automatic step(input bit c);
        bit ts, tl, st;
        int nxt;
        string tg;
        car_waiting = c;
        #1;
        ts = (m_s == 0);
        tl = (m_l == 0);
        nxt = m_state;
        case (m_state)
            0: if (tl && c) nxt = 1;
            1: if (ts) nxt = 3;
            3: if (tl && !c) nxt = 2;
            default: if (ts) nxt = 0;
        endcase
        st = (nxt != m_state);
        case (m_state)
            0: tg = "R2";
            1: tg = "R3";
            3: tg = "R4";
            default: tg = "R5";
        endcase
        chk(int'(phase) == m_state, {tg, " phase"}, phase, m_state);
        if (st) chk(start_timing == 1'b1, {tg, " start pulse"}, start_timing, 1);
        else    chk(start_timing == 1'b0, "R6 no pulse while holding", start_timing, 0);
        chk(short_done == ts, (m_s == 0) ? "R8 short flag" : "R7 short flag", short_done, ts);
        chk(long_done == tl, (m_l == 0) ? "R8 long flag" : "R7 long flag", long_done, tl);
        chk(int'({hwy_green, hwy_yellow, hwy_red, farm_green, farm_yellow, farm_red}) == lamps_for(m_state),
            "R9 lamps", {hwy_green, hwy_yellow, hwy_red, farm_green, farm_yellow, farm_red}, lamps_for(m_state));
        if (st) begin
            m_s = SHORT_LEN;
            m_l = LONG_LEN;
        end else begin
            if (m_s > 0) m_s--;
            if (m_l > 0) m_l--;
        end
        m_state = nxt;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(phase == 2'b00, "R1 reset phase", phase, 0);
        chk(hwy_green && farm_red && !hwy_yellow && !hwy_red && !farm_green && !farm_yellow,
            "R1 reset lamps", {hwy_green, farm_red}, 3);
        chk(!short_done && !long_done, "R1 reset flags", {short_done, long_done}, 0);
        rst_n = 1'b1;
        // R2: no vehicle keeps highway green past the long interval
        for (int i = 0; i < 30; i++) step(1'b0);
        chk(phase == 2'b00 && long_done, "R2 highway held without vehicle", phase, 0);
        // vehicle stays present through farm green (R4 hold)
        for (int i = 0; i < 60; i++) step(1'b1);
        chk(phase == 2'b11, "R4 farm green held while vehicle present", phase, 3);
        // vehicle leaves: farm yellow then highway green (R5)
        for (int i = 0; i < 40; i++) step(1'b0);
        chk(phase == 2'b00, "R5 back to highway green", phase, 0);
        // random arrivals
        for (int i = 0; i < 1500; i++) step(($urandom % 5) == 0);
        for (int i = 0; i < 1500; i++) step(($urandom % 3) != 0);
        for (int i = 0; i < 200; i++) step(1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule